// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block collects six interrupt source lines into one status register and turns them into a single host interrupt. Each source has its own bit in an enable register. While a source is enabled, a rising edge on its line latches its status bit to one. The bit stays set until software clears the matching enable bit. No separate clear register exists. The source lines may be asynchronous to the block clock, so each passes through a two-flop synchroniser before edge detection.

The host reaches both registers over a simple clocked register bus. Writes take effect on the clock edge. Read data is returned combinationally while a read is selected. The interrupt output pulses for one cycle when the status register goes from all-zero to non-zero. It does not pulse again until the status register has gone back to zero. A typical handler reads the status register, services the set sources, then clears their enable bits and sets them again. Clearing the enable bits empties the status register and re-arms the interrupt.

Top module: `irqLatchTop`

## Requirements
- R1: After reset the enable register and the status register both read as zero, and the interrupt output is low.
- R2: A write to address 0 loads the low six bits of the write data into the enable register. A read of address 0 returns the enable register in bits 5:0 with bits 7:6 zero.
- R3: When a source is enabled and its input line rises, its status bit (address 1, bit i for source i) reads as one after the third rising clock edge following the input change. That delay is two synchroniser flops plus the status flop.
- R4: A set status bit stays set after its source line falls and while its enable bit stays set.
- R5: A rising edge on a source whose enable bit is zero does not set its status bit. The edge is not remembered: enabling the source afterwards leaves the bit at zero.
- R6: A write that clears an enable bit clears the matching status bit on the same clock edge. Status bits whose enable stays set keep their value.
- R7: The interrupt output is high for exactly one cycle: the cycle right after the clock edge on which the status register went from all-zero to non-zero.
- R8: While the status register stays non-zero, further status bits may be set but no further interrupt pulse occurs. After it returns to zero, the next set bit produces a new pulse.
- R9: The status register is read-only and reading it does not change it. Writes to address 1 are ignored, and status reads return zero in bits 7:6.
- R10: A source line that is already high when its enable bit is set does not set its status bit. Only a later low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read, qualified by busSel |
| busAddr | input | 2 | Register address: 0 enable, 1 status |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, zero when no read is selected |
| srcIn | input | 6 | Interrupt source lines, may be asynchronous |
| irqOut | output | 1 | One-cycle interrupt pulse to the host |

## Verification
Every cycle, the assertions check three things. A status bit never rises while its enable was clear. A set bit falls only when its enable is gone. The interrupt pulse appears only on the first non-zero cycle of the status register and never while the register was already non-zero. Only the bench's scenarios can show the rest. That covers the exact three-edge latency from a source line to its status bit and the fact that a disabled edge is forgotten. It also covers a line that is already high at enable time, and the re-arming of the interrupt after the register has been emptied by clearing enables.

// File: rtl/irqLatchPkg.sv
package irqLatchPkg;

  typedef enum logic [1:0] {
    ADDR_ENABLE = 2'd0,
    ADDR_STATUS = 2'd1
  } regAddr_e;

  typedef struct packed {
    logic enableWr;
    logic readEnable;
    logic readStatus;
  } ctlStrobe_t;

endpackage

// File: rtl/irqLatchDatapath.sv
module irqLatchDatapath
  import irqLatchPkg::*;
#(
  parameter int NUM_SRC     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  ctlStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] enableReg,
  output logic [NUM_SRC-1:0] statusReg
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_SRC-1:0] syncStage [SYNC_STAGES];
  logic [NUM_SRC-1:0] prevLevel;
  logic [NUM_SRC-1:0] riseDet;
  logic [NUM_SRC-1:0] enableNext;
  logic [NUM_SRC-1:0] statusNext;

  // synchroniser chain
  always_ff @(posedge clk) begin
    if (rst) syncStage[0] <= '0;
    else     syncStage[0] <= srcIn;
  end

  generate
    for (genvar k = 1; k < SYNC_STAGES; k++) begin : gSync
      always_ff @(posedge clk) begin
        if (rst) syncStage[k] <= '0;
        else     syncStage[k] <= syncStage[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prevLevel <= '0;
    else     prevLevel <= syncStage[LAST];
  end

  assign riseDet    = syncStage[LAST] & ~prevLevel;
  assign enableNext = strobe.enableWr ? wrBits : enableReg;

  // an edge latches only if already enabled; a dropped enable clears
  assign statusNext = (statusReg | (riseDet & enableReg)) & enableNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      enableReg <= '0;
      statusReg <= '0;
    end else begin
      enableReg <= enableNext;
      statusReg <= statusNext;
    end
  end

  // R5: a status bit never rises unless its enable was set
  a_r5_no_set_when_disabled: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusReg & ~$past(statusReg) & ~$past(enableReg)) == '0));

  // R4 / R6: a set bit only falls when its enable is now clear
  a_r4_bit_holds_while_enabled: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~statusReg & $past(statusReg) & enableReg) == '0));

  // R6: write clearing enables empties those status bits on the same edge
  a_r6_clear_on_disable: assert property (@(posedge clk) disable iff (rst)
    strobe.enableWr |=> ((statusReg & ~$past(wrBits)) == '0));

endmodule

// File: rtl/irqLatchControl.sv
module irqLatchControl
  import irqLatchPkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] enableReg,
  input  logic [NUM_SRC-1:0] statusReg,
  output ctlStrobe_t         strobe,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic statusAny;
  logic statusWasAny;

  always_comb begin
    strobe            = '0;
    strobe.enableWr   = busSel && busWrite  && (busAddr == ADDR_ENABLE);
    strobe.readEnable = busSel && !busWrite && (busAddr == ADDR_ENABLE);
    strobe.readStatus = busSel && !busWrite && (busAddr == ADDR_STATUS);
  end

  always_comb begin
    busRdata = '0;
    if (strobe.readEnable)      busRdata = {{PAD_W{1'b0}}, enableReg};
    else if (strobe.readStatus) busRdata = {{PAD_W{1'b0}}, statusReg};
  end

  assign statusAny = |statusReg;

  always_ff @(posedge clk) begin
    if (rst) statusWasAny <= 1'b0;
    else     statusWasAny <= statusAny;
  end

  assign irqOut = statusAny && !statusWasAny;

  // R7: pulse lasts a single cycle
  a_r7_single_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    irqOut |=> !irqOut);

  // R8: no pulse while the register was already non-zero
  a_r8_no_repeat_irq: assert property (@(posedge clk) disable iff (rst)
    $past(statusReg != '0) |-> !irqOut);

  // R7: a zero-to-non-zero change of the status register always pulses
  a_r7_pulse_on_first_set: assert property (@(posedge clk) disable iff (rst)
    ((statusReg != '0) && $past(statusReg == '0)) |-> irqOut);

  // R2 / R9: upper read bits are zero
  a_r9_upper_read_zero: assert property (@(posedge clk) disable iff (rst)
    busRdata[DATA_W-1:NUM_SRC] == '0);

endmodule

// File: rtl/irqLatchTop.sv
module irqLatchTop
  import irqLatchPkg::*;
#(
  parameter int NUM_SRC     = 6,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut
);

  ctlStrobe_t         strobe;
  logic [NUM_SRC-1:0] enableReg;
  logic [NUM_SRC-1:0] statusReg;

  irqLatchControl #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) uCtl (
    .clk(clk), .rst(rst),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .enableReg(enableReg), .statusReg(statusReg),
    .strobe(strobe), .busRdata(busRdata), .irqOut(irqOut)
  );

  irqLatchDatapath #(
    .NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rst(rst),
    .strobe(strobe), .wrBits(busWdata[NUM_SRC-1:0]),
    .srcIn(srcIn),
    .enableReg(enableReg), .statusReg(statusReg)
  );

endmodule

// File: tb/irqLatchTop_test.sv
module irqLatchTop_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busSel = 1'b0;
  logic       busWrite = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic [5:0] srcIn = 6'd0;
  logic       irqOut;

  int checks = 0;
  int errors = 0;
  int irqCount = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqLatchTop uut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcIn(srcIn), .irqOut(irqOut)
  );

  always @(negedge clk) if (!rst && irqOut) irqCount++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #0.5 d = busRdata;
    #0.5 busSel = 1'b0;
  endtask

  // sets lines at a negedge and returns at the third negedge after it
  task automatic setSrc(input logic [5:0] v);
    @(negedge clk);
    srcIn = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    readReg(2'd0, d); check("R1 enable", d, 8'h00);
    readReg(2'd1, d); check("R1 status", d, 8'h00);
    check("R1 irq", irqOut, 0);
  endtask

  task automatic testRegAccess();
    logic [7:0] d;
    writeReg(2'd0, 8'hFF);
    readReg(2'd0, d); check("R2 enable readback", d, 8'h3F);
    writeReg(2'd1, 8'hFF);
    readReg(2'd1, d); check("R9 status write ignored", d, 8'h00);
  endtask

  task automatic testEdgeSet();
    logic [7:0] d;
    int c0;
    c0 = irqCount;
    @(negedge clk);
    srcIn = 6'b000001;
    repeat (2) @(negedge clk);
    check("R3 not yet after two edges", irqOut, 0);
    @(negedge clk);
    check("R7 irq pulse", irqOut, 1);
    readReg(2'd1, d);
    check("R3 status bit0", d, 8'h01);
    check("R7 pulse one cycle", irqOut, 0);
    check("R7 pulse count", irqCount - c0, 1);
    setSrc(6'b000000);
    readReg(2'd1, d); check("R4 held after fall", d, 8'h01);
    c0 = irqCount;
    setSrc(6'b000100);
    readReg(2'd1, d); check("R8 second bit latched", d, 8'h05);
    readReg(2'd1, d); check("R9 read stable", d, 8'h05);
    check("R8 no new irq", irqCount - c0, 0);
  endtask

  task automatic testClear();
    logic [7:0] d;
    int c0;
    c0 = irqCount;
    writeReg(2'd0, 8'h3E);
    readReg(2'd1, d); check("R6 bit0 cleared", d, 8'h04);
    writeReg(2'd0, 8'h3A);
    readReg(2'd1, d); check("R6 all cleared", d, 8'h00);
    setSrc(6'b000000);
    setSrc(6'b000010);
    readReg(2'd1, d); check("R8 rearmed status", d, 8'h02);
    check("R8 rearmed irq", irqCount - c0, 1);
    writeReg(2'd0, 8'h00);
    setSrc(6'b000000);
  endtask

  task automatic testDisabled();
    logic [7:0] d;
    int c0;
    c0 = irqCount;
    setSrc(6'b001000);
    readReg(2'd1, d); check("R5 disabled edge ignored", d, 8'h00);
    writeReg(2'd0, 8'h3F);
    repeat (4) @(negedge clk);
    readReg(2'd1, d); check("R10 high line at enable", d, 8'h00);
    check("R5 no irq", irqCount - c0, 0);
    setSrc(6'b000000);
    setSrc(6'b001000);
    readReg(2'd1, d); check("R3 later edge sets bit3", d, 8'h08);
    check("R7 irq for bit3", irqCount - c0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testRegAccess();
    testEdgeSet();
    testClear();
    testDisabled();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule